// File: doc/BRIEF.md
# Filtered Two-Wire Bus Condition Detector

This block sits between the raw open-drain clock and data lines of a two-wire serial bus (I2C) and the protocol engine of a slave device. It samples both lines with a fast system clock, passes them through a two-flop synchronizer and then through a per-line spike filter. A filtered level moves to a new value only after that value has been held for a programmable number of system clocks. From the two filtered levels it derives single-cycle event pulses for the protocol engine: bus START, bus STOP, clock rise (the point where data is sampled) and clock fall (the point where data may change). It also keeps a bus-busy flag.

The block also owns the slave's own drive onto the data line. The engine states only whether it wants the line pulled low. The block passes that request to the pad enable only while the filtered clock is low and a programmed number of clocks has elapsed since the last clock fall. A request made while the clock is high waits for the next fall and its hold window. As a result the slave never moves the data line inside the undefined region of a falling clock edge, and never while the clock is high, so it cannot create a false START or STOP. The pad enable only ever pulls low. A released line floats high through the bus pull-up.

Top module: `i2c_line_conditioner`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, both filtered levels read 1, `busy_o` is 0, `sda_pull_o` is 0 and no event pulse is asserted.
- R2: A change on a raw input that holds for fewer than `GLITCH_CYCLES` consecutive system clocks (after the synchronizer) changes no filtered level and produces no event. A change held for `GLITCH_CYCLES` clocks or more is accepted.
- R3: `start_o` pulses for exactly one cycle when filtered SDA goes from 1 to 0 while filtered SCL is 1 both before and after that change.
- R4: `stop_o` pulses for exactly one cycle when filtered SDA goes from 0 to 1 while filtered SCL is 1 both before and after that change. START and STOP never pulse together.
- R5: `busy_o` becomes 1 on the cycle after a START pulse and 0 on the cycle after a STOP pulse. A data-line change while filtered SCL is 0 creates no event and leaves `busy_o` unchanged.
- R6: `scl_rise_o` pulses for one cycle for each 0-to-1 change of filtered SCL, and `scl_fall_o` for each 1-to-0 change. The two never pulse together.
- R7: `sda_pull_o` changes only on an edge at which filtered SCL was 0, and only when more than `SDA_HOLD_CYCLES` clocks have passed since the last `scl_fall_o` pulse. A change of `tx_low_req_i` made while SCL is high leaves `sda_pull_o` unchanged until after the next fall.
- R8: A request that is pending at a clock fall appears on `sda_pull_o` exactly `SDA_HOLD_CYCLES`+2 clocks after the cycle in which `scl_fall_o` is 1. A request changed while SCL is low and the hold window has expired appears on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock line level |
| sda_i | input | 1 | Raw bus data line level |
| tx_low_req_i | input | 1 | Protocol engine wants the data line pulled low |
| scl_filt_o | output | 1 | Filtered clock line level |
| sda_filt_o | output | 1 | Filtered data line level |
| start_o | output | 1 | One-cycle START event |
| stop_o | output | 1 | One-cycle STOP event |
| scl_rise_o | output | 1 | One-cycle clock rise (sample point) |
| scl_fall_o | output | 1 | One-cycle clock fall (shift point) |
| busy_o | output | 1 | Bus is between a START and a STOP |
| sda_pull_o | output | 1 | Pull-down enable for the data pad; 0 releases the line |

## Verification
The bench builds the block with `GLITCH_CYCLES` = 3 and `SDA_HOLD_CYCLES` = 5. With these values, pulses just under and just over the filter threshold can be driven in a handful of cycles, and the exact hold-window latency after a clock fall can be measured to the cycle. The small filter also lets a single accepted data-line pulse with the clock high produce a back-to-back START and STOP pair. The small hold window makes the deferral of a request raised while the clock is high visible across several clock phases.

// File: rtl/i2cc_pkg.sv
package i2cc_pkg;
    localparam int LINE_SCL  = 0;
    localparam int LINE_SDA  = 1;
    localparam int NUM_LINES = 2;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;
endpackage

// File: rtl/i2cc_sync2.sv
module i2cc_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= '1;
            st_q.s2 <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/i2cc_deglitch.sv
module i2cc_deglitch #(
    parameter int GLITCH_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o
);
    localparam int CW = $clog2(GLITCH_CYCLES + 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } flt_st_t;

    flt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (line_i != st_q.lvl) begin
            if (st_q.cnt == CW'(GLITCH_CYCLES - 1)) begin
                st_d.lvl = line_i;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl <= 1'b1;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.lvl;
endmodule

// File: rtl/i2cc_event_det.sv
module i2cc_event_det
    import i2cc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_lvl_i,
    input  logic     sda_lvl_i,
    output bus_evt_t evt_o,
    output logic     busy_o
);
    typedef struct packed {
        logic scl_p;
        logic sda_p;
        logic busy;
    } det_st_t;

    det_st_t  st_d, st_q;
    bus_evt_t evt;

    always_comb begin
        evt.start = st_q.scl_p & scl_lvl_i & st_q.sda_p & ~sda_lvl_i;
        evt.stop  = st_q.scl_p & scl_lvl_i & ~st_q.sda_p & sda_lvl_i;
        evt.rise  = ~st_q.scl_p & scl_lvl_i;
        evt.fall  = st_q.scl_p & ~scl_lvl_i;

        st_d       = st_q;
        st_d.scl_p = scl_lvl_i;
        st_d.sda_p = sda_lvl_i;
        if (evt.start) begin
            st_d.busy = 1'b1;
        end else if (evt.stop) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.scl_p <= 1'b1;
            st_q.sda_p <= 1'b1;
            st_q.busy  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o  = evt;
    assign busy_o = st_q.busy;
endmodule

// File: rtl/i2cc_sda_hold.sv
module i2cc_sda_hold #(
    parameter int SDA_HOLD_CYCLES = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl_i,
    input  logic scl_fall_i,
    input  logic low_req_i,
    output logic pull_o
);
    localparam int HW = $clog2(SDA_HOLD_CYCLES + 2);

    typedef struct packed {
        logic          pull;
        logic [HW-1:0] cnt;
    } hold_st_t;

    hold_st_t st_d, st_q;
    logic     may_move;

    always_comb begin
        st_d = st_q;
        if (scl_fall_i) begin
            st_d.cnt = HW'(SDA_HOLD_CYCLES);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end

        may_move = ~scl_lvl_i & ~scl_fall_i & (st_q.cnt == '0);
        if (may_move) begin
            st_d.pull = low_req_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pull <= 1'b0;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pull_o = st_q.pull;
endmodule

// File: rtl/i2c_line_conditioner.sv
module i2c_line_conditioner
    import i2cc_pkg::*;
#(
    parameter int GLITCH_CYCLES   = 6,
    parameter int SDA_HOLD_CYCLES = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic tx_low_req_i,
    output logic scl_filt_o,
    output logic sda_filt_o,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic busy_o,
    output logic sda_pull_o
);
    logic [NUM_LINES-1:0] raw_vec;
    logic [NUM_LINES-1:0] sync_vec;
    logic [NUM_LINES-1:0] filt_vec;
    bus_evt_t             evt;

    assign raw_vec[LINE_SCL] = scl_i;
    assign raw_vec[LINE_SDA] = sda_i;

    i2cc_sync2 #(.W(NUM_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_vec),
        .sync_o  (sync_vec)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        i2cc_deglitch #(.GLITCH_CYCLES(GLITCH_CYCLES)) u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (sync_vec[g]),
            .level_o (filt_vec[g])
        );
    end

    i2cc_event_det u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl_i (filt_vec[LINE_SCL]),
        .sda_lvl_i (filt_vec[LINE_SDA]),
        .evt_o     (evt),
        .busy_o    (busy_o)
    );

    i2cc_sda_hold #(.SDA_HOLD_CYCLES(SDA_HOLD_CYCLES)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_lvl_i  (filt_vec[LINE_SCL]),
        .scl_fall_i (evt.fall),
        .low_req_i  (tx_low_req_i),
        .pull_o     (sda_pull_o)
    );

    assign scl_filt_o = filt_vec[LINE_SCL];
    assign sda_filt_o = filt_vec[LINE_SDA];
    assign start_o    = evt.start;
    assign stop_o     = evt.stop;
    assign scl_rise_o = evt.rise;
    assign scl_fall_o = evt.fall;
endmodule

// File: rtl/i2cc_checker.sv
module i2cc_checker #(
    parameter int HOLD = 30
) (
    input logic clk,
    input logic rst_n,
    input logic scl_filt,
    input logic start,
    input logic stop,
    input logic rise,
    input logic fall,
    input logic busy,
    input logic pull
);
    localparam int SW = $clog2(HOLD + 2) + 1;
    localparam logic [SW-1:0] CAP = SW'(HOLD + 1);

    logic [SW-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= CAP;
        end else if (fall) begin
            since_q <= '0;
        end else if (since_q < CAP) begin
            since_q <= since_q + 1'b1;
        end
    end

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> !(start || stop || rise || fall || busy || pull));

    a_r3_start_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> scl_filt);

    a_r4_stop_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        stop |-> scl_filt);

    a_r4_start_stop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && stop));

    a_r5_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    a_r5_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !busy);

    a_r6_edge_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));

    a_r6_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> scl_filt);

    a_r7_move_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pull != $past(pull)) |-> !$past(scl_filt));

    a_r7_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
        (pull != $past(pull)) |-> (since_q > SW'(HOLD)));
endmodule

bind i2c_line_conditioner i2cc_checker #(.HOLD(SDA_HOLD_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_filt (scl_filt_o),
    .start    (start_o),
    .stop     (stop_o),
    .rise     (scl_rise_o),
    .fall     (scl_fall_o),
    .busy     (busy_o),
    .pull     (sda_pull_o)
);

// File: tb/i2c_line_conditioner_bench.sv
module i2c_line_conditioner_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FILT       = 3;
    localparam int HOLD       = 5;
    localparam int SETTLE     = FILT + 8;
    localparam int EV_START   = 0;
    localparam int EV_STOP    = 1;
    localparam int EV_RISE    = 2;
    localparam int EV_FALL    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_i = 1'b1;
    logic sda_i = 1'b1;
    logic req = 1'b0;
    logic scl_filt, sda_filt, ev_start, ev_stop, ev_rise, ev_fall, busy, pull;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int last_fall_cyc = 0;
    bit done = 1'b0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_line_conditioner #(
        .GLITCH_CYCLES   (FILT),
        .SDA_HOLD_CYCLES (HOLD)
    ) u_i2c_line_conditioner (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_i),
        .sda_i        (sda_i),
        .tx_low_req_i (req),
        .scl_filt_o   (scl_filt),
        .sda_filt_o   (sda_filt),
        .start_o      (ev_start),
        .stop_o       (ev_stop),
        .scl_rise_o   (ev_rise),
        .scl_fall_o   (ev_fall),
        .busy_o       (busy),
        .sda_pull_o   (pull)
    );

    function automatic string ev_req(int code);
        case (code)
            EV_START: return "R3";
            EV_STOP:  return "R4";
            default:  return "R6";
        endcase
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
        end
    endtask

    task automatic see_event(input int code);
        int expv;
        compared++;
        if (exp_q.size() == 0) begin
            mismatched++;
            $display("FAIL %s unexpected event: actual %0d expected none", ev_req(code), code);
        end else begin
            expv = exp_q.pop_front();
            if (expv != code) begin
                mismatched++;
                $display("FAIL %s event order: actual %0d expected %0d", ev_req(expv), code, expv);
            end
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (ev_fall) last_fall_cyc = cyc;
            if (ev_start) see_event(EV_START);
            if (ev_stop)  see_event(EV_STOP);
            if (ev_rise)  see_event(EV_RISE);
            if (ev_fall)  see_event(EV_FALL);
        end
    end

    task automatic drained(input string rq);
        chk(exp_q.size() == 0, rq, "expected events still pending", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic move(input logic ns, input logic nd, input string rq);
        if (ns != scl_i) exp_q.push_back(ns ? EV_RISE : EV_FALL);
        else if (nd != sda_i && scl_i) exp_q.push_back(nd ? EV_STOP : EV_START);
        @(negedge clk);
        scl_i = ns;
        sda_i = nd;
        repeat (SETTLE) @(negedge clk);
        drained(rq);
    endtask

    task automatic sda_pulse_low(input int len);
        if (len >= FILT) begin
            exp_q.push_back(EV_START);
            exp_q.push_back(EV_STOP);
        end
        @(negedge clk);
        sda_i = 1'b0;
        repeat (len) @(negedge clk);
        sda_i = 1'b1;
        repeat (SETTLE) @(negedge clk);
        drained("R2");
    endtask

    task automatic scl_pulse_low(input int len);
        @(negedge clk);
        scl_i = 1'b0;
        repeat (len) @(negedge clk);
        scl_i = 1'b1;
        repeat (SETTLE) @(negedge clk);
        drained("R2");
    endtask

    // Drop SCL and measure the cycles from the fall pulse to the drive change
    task automatic fall_and_time(input logic want, input string rq);
        int delta;
        bit seen;
        exp_q.push_back(EV_FALL);
        @(negedge clk);
        scl_i = 1'b0;
        seen = 1'b0;
        delta = -1;
        for (int i = 0; i < 60 && !seen; i++) begin
            @(negedge clk);
            if (pull == want) begin
                seen = 1'b1;
                delta = cyc - last_fall_cyc;
            end
        end
        chk(delta == HOLD + 2, rq, "clocks from fall pulse to drive change", delta, HOLD + 2);
        repeat (4) @(negedge clk);
        drained("R6");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: values during reset
        chk(scl_filt && sda_filt, "R1", "filtered levels in reset", {scl_filt, sda_filt}, 3);
        chk(!busy && !pull, "R1", "busy/pull in reset", {busy, pull}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!(ev_start || ev_stop || ev_rise || ev_fall), "R1", "pulses after reset",
            {ev_start, ev_stop, ev_rise, ev_fall}, 0);
        chk(scl_filt && sda_filt && !busy && !pull, "R1", "state after reset",
            {scl_filt, sda_filt, busy, pull}, 12);
        repeat (4) @(negedge clk);

        // Full transaction framing
        move(1'b1, 1'b0, "R3");
        chk(busy == 1'b1, "R5", "busy after START", busy, 1);
        move(1'b0, 1'b0, "R6");
        move(1'b0, 1'b1, "R5");
        chk(busy == 1'b1, "R5", "busy after data change with SCL low", busy, 1);
        chk(sda_filt == 1'b1, "R5", "filtered SDA follows while SCL low", sda_filt, 1);
        move(1'b0, 1'b0, "R5");
        move(1'b1, 1'b0, "R6");
        chk(busy == 1'b1, "R5", "busy held across rise", busy, 1);
        move(1'b1, 1'b1, "R4");
        chk(busy == 1'b0, "R5", "busy after STOP", busy, 0);

        // Spike filtering
        scl_pulse_low(FILT - 1);
        chk(scl_filt == 1'b1, "R2", "SCL after short spike", scl_filt, 1);
        sda_pulse_low(FILT - 1);
        chk(busy == 1'b0, "R2", "busy after short SDA spike", busy, 0);
        sda_pulse_low(FILT + 1);
        chk(busy == 1'b0, "R2", "busy after accepted START/STOP pulse", busy, 0);
        move(1'b1, 1'b0, "R3");
        chk(busy == 1'b1, "R5", "busy after second START", busy, 1);

        // Output drive: request raised while SCL high is deferred
        @(negedge clk);
        req = 1'b1;
        repeat (10) @(negedge clk);
        chk(pull == 1'b0, "R7", "drive moved while SCL high", pull, 0);
        fall_and_time(1'b1, "R8");
        chk(pull == 1'b1, "R8", "drive after hold window", pull, 1);

        // SCL low, window expired: next clock
        req = 1'b0;
        @(negedge clk);
        chk(pull == 1'b0, "R8", "drive release with window expired", pull, 0);
        req = 1'b1;
        @(negedge clk);
        chk(pull == 1'b1, "R8", "drive apply with window expired", pull, 1);

        // Rise, change request while high, then fall
        move(1'b1, 1'b0, "R6");
        req = 1'b0;
        repeat (10) @(negedge clk);
        chk(pull == 1'b1, "R7", "release deferred while SCL high", pull, 1);
        fall_and_time(1'b0, "R8");
        chk(pull == 1'b0, "R7", "drive released after fall", pull, 0);

        move(1'b0, 1'b0, "R5");
        move(1'b1, 1'b0, "R6");
        move(1'b1, 1'b1, "R4");
        chk(busy == 1'b0, "R5", "busy after final STOP", busy, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule